// File: doc/BRIEF.md
# Masked SIMD Processing Element Array

This block is the array side of a single-instruction multiple-data machine. A control unit presents one instruction per cycle on the instruction inputs. The instruction carries an opcode, a data format, a word address and a scalar operand. Every processing element (PE) that has its activity flag set carries it out in the same cycle. The array follows an element-per-PE layout, so element i of a vector lives in PE i. Each PE holds a private word memory, an accumulator, a routing register and an activity flag.

Arithmetic works on the full 64-bit word, on two 32-bit lanes or on eight 8-bit lanes, and carries never cross a lane edge. A route instruction moves every active PE's routing register one step around a ring. The control unit can broadcast a scalar into the accumulators. It can also pull any single word out of a chosen PE's memory through a registered read-back path.

The model is reduced: the PE count, word width and memory depth are parameters. The memory depth defaults to 64 words per PE and can be raised to 2048 for the full-size arrangement.

Top module: `simd_pe_array`

## Requirements
- R1: An instruction with `valid_i` high runs in every PE whose activity flag is set, and all of them update on the same clock edge.
- R2: A PE whose flag is clear leaves its accumulator, routing register and memory unchanged for every opcode other than 13 and 14.
- R3: Opcode 13 (set-activity) loads PE i's flag from `scalar_i[i]` in every PE, whether it is active or not. `act_o[i]` shows PE i's flag.
- R4: Format 0, and also the unused format 3, adds and subtracts one 64-bit word with the carry running through all 64 bits.
- R5: Format 1 treats bits [31:0] and [63:32] as independent lanes, and no carry or borrow passes from bit 31 into bit 32.
- R6: Format 2 treats each byte as an independent lane, and no carry or borrow passes between bytes.
- R7: ADD (3) and SUB (4) combine the accumulator with the memory word at `addr_i` in each lane, modulo the lane width. AND (5), OR (6) and XOR (7) do the same bitwise.
- R8: Opcode 10 sets each active PE i's routing register to the old routing register of PE (i+1) mod N. Opcode 11 takes it from PE (i-1) mod N instead, so the ring wraps at both ends.
- R9: Opcode 8 copies `scalar_i` into the accumulator of every active PE.
- R10: Opcode 14 (read) drives the word at `addr_i` of PE `sel_i` on `rd_data_o` one cycle later with `rd_valid_o` high. The read ignores the activity flags. `rd_valid_o` is low in every cycle that does not follow a read.
- R11: Opcodes LDA (1), STA (2), MOVR (9) and MOVA (12) copy memory to the accumulator, the accumulator to memory, the accumulator to the routing register, and the routing register to the accumulator.
- R12: After reset, all flags are set and every accumulator, routing register and memory word is zero. `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| op_i | input | 4 | Opcode |
| fmt_i | input | 2 | Lane format: 0 word, 1 two 32-bit, 2 eight 8-bit |
| addr_i | input | ADDR_W | PE memory word address |
| scalar_i | input | WORD_W | Broadcast scalar / activity pattern |
| sel_i | input | SEL_W | PE selected for read-back |
| rd_valid_o | output | 1 | Read-back word valid |
| rd_data_o | output | WORD_W | Read-back word |
| act_o | output | NUM_PE | Activity flag of each PE |

## Verification
On every cycle, the assertions check four things: the hold of accumulator and routing register in inactive PEs, the broadcast load, the one-cycle read-back strobe, and the loading of the flags. The carry isolation between lanes, the ring wraparound, and the fact that inactive PEs do not write memory can be seen only through the bench's scenarios. Those scenarios store results, read them back through the read port, and compare them with a model in the bench. Directed sums at the lane edges, for example all-ones bytes plus one, show the carry behaviour of each format.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LDA   = 4'd1,
    OP_STA   = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_BCAST = 4'd8,
    OP_MOVR  = 4'd9,
    OP_ROUTL = 4'd10,
    OP_ROUTR = 4'd11,
    OP_MOVA  = 4'd12,
    OP_SETACT= 4'd13,
    OP_READ  = 4'd14,
    OP_RSVD  = 4'd15
  } op_e;

  localparam logic [1:0] FMT_W64 = 2'd0;
  localparam logic [1:0] FMT_W32 = 2'd1;
  localparam logic [1:0] FMT_W8  = 2'd2;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  op_e               op_i,
  input  logic [1:0]        fmt_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] y_o
);
  localparam int NB = WORD_W / 8;

  logic              sub;
  logic [WORD_W-1:0] bx, sum;
  logic [8:0]        s;
  logic              c;

  // byte-sliced adder; carry chain restarts at each lane start
  always_comb begin
    sub = (op_i == OP_SUB);
    bx  = sub ? ~b_i : b_i;
    c   = sub;
    sum = '0;
    s   = '0;
    for (int j = 0; j < NB; j++) begin
      if (j != 0 && ((fmt_i == FMT_W8) || (fmt_i == FMT_W32 && (j % 4) == 0)))
        c = sub;
      s = {1'b0, a_i[8*j +: 8]} + {1'b0, bx[8*j +: 8]} + {8'd0, c};
      sum[8*j +: 8] = s[7:0];
      c = s[8];
    end
  end

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: y_o = sum;
      OP_AND:         y_o = a_i & b_i;
      OP_OR:          y_o = a_i | b_i;
      OP_XOR:         y_o = a_i ^ b_i;
      default:        y_o = a_i;
    endcase
  end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  op_e               op_i,
  input  logic [1:0]        fmt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] scalar_i,
  input  logic              act_set_i,
  input  logic [WORD_W-1:0] from_next_i,
  input  logic [WORD_W-1:0] from_prev_i,
  output logic [WORD_W-1:0] rt_o,
  output logic              act_o,
  output logic [WORD_W-1:0] mem_word_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] acc_q, rt_q, alu_y, mem_rd;
  logic              act_q, do_op;

  assign mem_rd     = mem_q[addr_i];
  assign do_op      = valid_i && act_q;
  assign rt_o       = rt_q;
  assign act_o      = act_q;
  assign mem_word_o = mem_rd;

  simd_lane_alu #(.WORD_W(WORD_W)) alu_i (
    .op_i (op_i),
    .fmt_i(fmt_i),
    .a_i  (acc_q),
    .b_i  (mem_rd),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rt_q  <= '0;
    end else if (do_op) begin
      case (op_i)
        OP_LDA:                          acc_q <= mem_rd;
        OP_ADD, OP_SUB, OP_AND, OP_OR,
        OP_XOR:                          acc_q <= alu_y;
        OP_BCAST:                        acc_q <= scalar_i;
        OP_MOVA:                         acc_q <= rt_q;
        OP_MOVR:                         rt_q  <= acc_q;
        OP_ROUTL:                        rt_q  <= from_next_i;
        OP_ROUTR:                        rt_q  <= from_prev_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             act_q <= 1'b1;
    else if (valid_i && op_i == OP_SETACT)   act_q <= act_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (do_op && op_i == OP_STA) begin
      mem_q[addr_i] <= acc_q;
    end
  end

  a_r2_inactive_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !act_q) |=> ($stable(acc_q) && $stable(rt_q)));

  a_r9_bcast_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && act_q && op_i == OP_BCAST) |=> (acc_q == $past(scalar_i)));
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int SEL_W  = $clog2(NUM_PE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        fmt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] scalar_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [NUM_PE-1:0] act_o
);
  op_e               op;
  logic [WORD_W-1:0] rt_w   [NUM_PE];
  logic [WORD_W-1:0] word_w [NUM_PE];

  assign op = op_e'(op_i);

  for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
    simd_pe #(.WORD_W(WORD_W), .DEPTH(DEPTH)) pe_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (valid_i),
      .op_i       (op),
      .fmt_i      (fmt_i),
      .addr_i     (addr_i),
      .scalar_i   (scalar_i),
      .act_set_i  (scalar_i[i]),
      .from_next_i(rt_w[(i + 1) % NUM_PE]),
      .from_prev_i(rt_w[(i + NUM_PE - 1) % NUM_PE]),
      .rt_o       (rt_w[i]),
      .act_o      (act_o[i]),
      .mem_word_o (word_w[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= valid_i && op == OP_READ;
      if (valid_i && op == OP_READ) rd_data_o <= word_w[sel_i];
    end
  end

  a_r10_rd_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_READ) |=> rd_valid_o);

  a_r10_rd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op == OP_READ) |=> !rd_valid_o);

  a_r3_act_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_SETACT) |=> (act_o == $past(scalar_i[NUM_PE-1:0])));
endmodule

// File: tb/simd_pe_array_tb.sv
module simd_pe_array_tb_top;
  import simd_pkg::*;
  localparam int N = 8;
  localparam int W = 64;
  localparam int D = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [3:0]   op = '0;
  logic [1:0]   fmt = '0;
  logic [5:0]   addr = '0;
  logic [W-1:0] scalar = '0;
  logic [2:0]   sel = '0;
  logic         rd_valid;
  logic [W-1:0] rd_data;
  logic [N-1:0] act;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [W-1:0] m_acc [N];
  logic [W-1:0] m_rt  [N];
  logic         m_act [N];
  logic [W-1:0] m_mem [N][D];

  always #10 clk = ~clk;

  simd_pe_array dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .fmt_i(fmt),
    .addr_i(addr), .scalar_i(scalar), .sel_i(sel),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .act_o(act)
  );

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_alu(op_e o, logic [1:0] f, logic [W-1:0] a, logic [W-1:0] b);
    int lw;
    logic [W-1:0] res, msk, la, lb, lr;
    case (o)
      OP_AND: return a & b;
      OP_OR:  return a | b;
      OP_XOR: return a ^ b;
      default: ;
    endcase
    lw  = (f == 2'd1) ? 32 : (f == 2'd2) ? 8 : 64;
    msk = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    res = '0;
    for (int k = 0; k < W / lw; k++) begin
      la = (a >> (k * lw)) & msk;
      lb = (b >> (k * lw)) & msk;
      lr = ((o == OP_SUB) ? (la - lb) : (la + lb)) & msk;
      res |= lr << (k * lw);
    end
    return res;
  endfunction

  task automatic model_exec(op_e o, logic [1:0] f, logic [5:0] ad, logic [W-1:0] sc);
    logic [W-1:0] old_rt [N];
    for (int i = 0; i < N; i++) old_rt[i] = m_rt[i];
    if (o == OP_SETACT) begin
      for (int i = 0; i < N; i++) m_act[i] = sc[i];
      return;
    end
    for (int i = 0; i < N; i++) begin
      if (m_act[i]) begin
        case (o)
          OP_LDA:   m_acc[i] = m_mem[i][ad];
          OP_STA:   m_mem[i][ad] = m_acc[i];
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR:
                    m_acc[i] = ref_alu(o, f, m_acc[i], m_mem[i][ad]);
          OP_BCAST: m_acc[i] = sc;
          OP_MOVR:  m_rt[i] = m_acc[i];
          OP_MOVA:  m_acc[i] = old_rt[i];
          OP_ROUTL: m_rt[i] = old_rt[(i + 1) % N];
          OP_ROUTR: m_rt[i] = old_rt[(i + N - 1) % N];
          default: ;
        endcase
      end
    end
  endtask

  task automatic issue(op_e o, logic [1:0] f, logic [5:0] ad, logic [W-1:0] sc);
    @(negedge clk);
    valid = 1'b1; op = o; fmt = f; addr = ad; scalar = sc;
    @(negedge clk);
    valid = 1'b0; op = OP_NOP;
    model_exec(o, f, ad, sc);
  endtask

  task automatic rd(string req, logic [2:0] pe, logic [5:0] ad);
    @(negedge clk);
    valid = 1'b1; op = OP_READ; addr = ad; sel = pe;
    @(negedge clk);
    valid = 1'b0; op = OP_NOP;
    chk(req, {63'd0, rd_valid}, 64'd1);
    chk(req, rd_data, m_mem[pe][ad]);
  endtask

  task automatic set_act(logic [N-1:0] m);
    issue(OP_SETACT, 2'd0, 6'd0, {56'd0, m});
    chk("R3", {56'd0, act}, {56'd0, m});
  endtask

  // store acc into addr and read back word for pe p, compare with a literal
  task automatic lane_case(string req, logic [1:0] f, logic [W-1:0] a, logic [W-1:0] b,
                           op_e o, logic [W-1:0] exp);
    set_act('1);
    issue(OP_BCAST, 2'd0, 6'd0, b);
    issue(OP_STA, 2'd0, 6'd40, 64'd0);
    issue(OP_BCAST, 2'd0, 6'd0, a);
    issue(o, f, 6'd40, 64'd0);
    issue(OP_STA, 2'd0, 6'd41, 64'd0);
    rd(req, 3'd3, 6'd41);
    chk(req, m_mem[3][41], exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] tmp;
    for (int i = 0; i < N; i++) begin
      m_acc[i] = '0; m_rt[i] = '0; m_act[i] = 1'b1;
      for (int k = 0; k < D; k++) m_mem[i][k] = '0;
    end
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", {63'd0, rd_valid}, 64'd0);
    chk("R12", {56'd0, act}, {56'd0, {N{1'b1}}});
    rd("R12", 3'd5, 6'd9);
    issue(OP_NOP, 2'd0, 6'd0, 64'd0);
    chk("R10", {63'd0, rd_valid}, 64'd0);

    // R4/R5/R6/R7 lane boundaries
    lane_case("R4", 2'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, OP_ADD, 64'h0000_0001_0000_0000);
    lane_case("R4", 2'd3, 64'h0000_0000_FFFF_FFFF, 64'd1, OP_ADD, 64'h0000_0001_0000_0000);
    lane_case("R5", 2'd1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0001, OP_ADD, 64'h0000_0001_0000_0000);
    lane_case("R6", 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, OP_ADD, 64'h0000_0000_0000_0000);
    lane_case("R7", 2'd2, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, OP_SUB, 64'hFFFF_FFFF_FFFF_FFFF);
    lane_case("R5", 2'd1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, OP_SUB, 64'h0000_0001_FFFF_FFFF);
    lane_case("R7", 2'd0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, OP_SUB, 64'h0000_0000_FFFF_FFFF);
    lane_case("R7", 2'd0, 64'hF0F0_0000_FFFF_1234, 64'h0FF0_FFFF_00FF_0000, OP_XOR, 64'hFF00_FFFF_FF00_1234);

    // R2 masking: odd PEs only get a broadcast stored
    set_act(8'hAA);
    issue(OP_BCAST, 2'd0, 6'd0, 64'hDEAD_BEEF_0000_0005);
    issue(OP_STA, 2'd0, 6'd5, 64'd0);
    rd("R2", 3'd0, 6'd5);
    rd("R1", 3'd1, 6'd5);
    chk("R2", m_mem[0][5], 64'd0);

    // R8 route: give each PE a distinct rt value
    for (int i = 0; i < N; i++) begin
      set_act(8'd1 << i);
      issue(OP_BCAST, 2'd0, 6'd0, 64'h100 + i);
      issue(OP_MOVR, 2'd0, 6'd0, 64'd0);
    end
    set_act('1);
    issue(OP_ROUTL, 2'd0, 6'd0, 64'd0);
    issue(OP_MOVA, 2'd0, 6'd0, 64'd0);
    issue(OP_STA, 2'd0, 6'd7, 64'd0);
    rd("R8", 3'd7, 6'd7);
    chk("R8", m_mem[7][7], 64'h100);
    issue(OP_ROUTR, 2'd0, 6'd0, 64'd0);
    issue(OP_ROUTR, 2'd0, 6'd0, 64'd0);
    issue(OP_MOVA, 2'd0, 6'd0, 64'd0);
    issue(OP_STA, 2'd0, 6'd8, 64'd0);
    rd("R8", 3'd0, 6'd8);
    chk("R8", m_mem[0][8], 64'h107);
    // inactive PE keeps rt during route
    set_act(8'hFE);
    issue(OP_ROUTL, 2'd0, 6'd0, 64'd0);
    set_act('1);
    issue(OP_MOVA, 2'd0, 6'd0, 64'd0);
    issue(OP_STA, 2'd0, 6'd9, 64'd0);
    for (int i = 0; i < N; i++) rd("R2", 3'(i), 6'd9);

    // random phase
    for (int n = 0; n < 400; n++) begin
      int r;
      op_e o;
      r = $urandom_range(0, 12);
      case (r)
        0: o = OP_LDA;   1: o = OP_STA;   2: o = OP_ADD;   3: o = OP_SUB;
        4: o = OP_AND;   5: o = OP_OR;    6: o = OP_XOR;   7: o = OP_BCAST;
        8: o = OP_MOVR;  9: o = OP_ROUTL; 10: o = OP_ROUTR; 11: o = OP_MOVA;
        default: o = OP_SETACT;
      endcase
      tmp = {$urandom, $urandom};
      issue(o, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 7)), tmp);
      if (o == OP_SETACT) chk("R3", {56'd0, act}, {56'd0, tmp[7:0]});
    end
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 8; k++) rd("R1", 3'(i), 6'(k));
    set_act('1);
    issue(OP_STA, 2'd0, 6'd60, 64'd0);
    issue(OP_MOVA, 2'd0, 6'd0, 64'd0);
    issue(OP_STA, 2'd0, 6'd61, 64'd0);
    for (int i = 0; i < N; i++) begin
      rd("R11", 3'(i), 6'd60);
      rd("R11", 3'(i), 6'd61);
    end
    issue(OP_NOP, 2'd0, 6'd0, 64'd0);
    chk("R10", {63'd0, rd_valid}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule